// File: doc/BRIEF.md
# Periodic Interval Timer

This block generates a regular time base for a processor subsystem. A free-running prescaler divides the system clock by 16. Each prescaler tick moves a 20-bit counter one step up, from zero to a programmed interval value. On the next tick after that value the counter returns to zero. Every return to zero is counted in a 12-bit overflow field and raises a sticky status flag. When interrupts are enabled, the flag drives a level interrupt.

Software controls the timer through a small 32-bit register bus with separate read and write strobes. The value register is the acknowledging view: reading it returns the overflow count and the counter, then clears the count and the flag. A second, image view returns the same word and changes nothing. When the enable bit is cleared, the counter does not stop at once. It finishes its current period, parks at zero and stays there until it is enabled again.

Top module: `interval_timer`

## Requirements
- R1: Word registers: offset 0x00 control (bits 19:0 interval, bit 24 run enable, bit 25 interrupt enable, all other bits read 0), offset 0x04 status (bit 0 interval flag, other bits 0), offset 0x08 value and offset 0x0C image (both {overflow count in 31:20, counter in 19:0}). Read data is combinational in the cycle the read strobe is high, and is zero while no read is strobed.
- R2: A write to the control register updates its fields from the next clock cycle on, and the fields read back as written.
- R3: While running, the counter advances once every 16 clock cycles. From a stopped state, the first advance comes on the 16th rising edge after the edge that writes the enable.
- R4: The counter steps 0, 1, ..., interval and then returns to 0, so one period lasts (interval + 1) * 16 clock cycles.
- R5: Each return of the counter to 0 increments the overflow count and sets the status flag.
- R6: A read at offset 0x08 returns the current word, then clears the overflow count and the status flag. A read at offset 0x0C changes no state.
- R7: When the run enable is cleared, the counter keeps stepping until it returns to 0, then holds at 0. That final return still counts as an overflow.
- R8: The interrupt output is high exactly when the status flag is 1 and the interrupt enable is 1.
- R9: The overflow count saturates at 4095.
- R10: The interval used for a period is the programmed value at the time the counter leaves 0. A value written while the counter is non-zero applies from the following period on.
- R11: Reset clears all registers, stops the counter at 0 and returns the prescaler phase to 0.
- R12: Writes to offsets 0x04, 0x08 and 0x0C and to unmapped or misaligned addresses change nothing. Reads from unmapped addresses return 0.
- R13: If a read at 0x08 falls on the same edge as a counter return to 0, the read returns the pre-return word. Afterwards the overflow count is 1 and the status flag is 1, so the new interval is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledging read that lands on the very edge where the counter returns to zero. The bench starts the timer from a stopped state with a known prescaler phase, so it can compute that edge exactly. It then holds a value read across that edge and checks that the returned word and the count and flag left behind match a wrap that was kept. Saturation is reached with a zero interval, so an overflow occurs every 16 cycles, and the bench waits out more than 4096 of them.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

    // word selector taken from address bits 3:2
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_VALUE = 2'd2,
        SEL_IMAGE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
module ivt_prescaler #(
    parameter int PRE_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [PRE_LOG2-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = run ? phase_q + 1'b1 : '0;
        tick    = run && (phase_q == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // R3: ticks are never back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
module ivt_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] interval,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] lim_eff;
    logic             at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        lim_eff = at_zero ? interval : st_q.lim;
        run     = en || !at_zero;
        wrap    = tick && (st_q.cnt == lim_eff);
        if (at_zero) st_d.lim = interval;
        if (tick)    st_d.cnt = wrap ? '0 : st_q.cnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> st_q.cnt == $past(st_q.cnt) + ONE);
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.cnt == '0);
    a_r7_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && st_q.cnt == '0) |=> st_q.cnt == '0);
endmodule

// File: rtl/ivt_events.sv
`timescale 1ns/1ps
module ivt_events #(
    parameter int OVF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             ack,
    output logic [OVF_W-1:0] ovf,
    output logic             flag
);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;
    localparam logic [OVF_W-1:0] OVF_ONE = {{(OVF_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [OVF_W-1:0] ovf;
        logic             flag;
    } ev_state_t;

    ev_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack) begin
            st_d.ovf  = '0;
            st_d.flag = 1'b0;
        end
        if (wrap) begin
            st_d.flag = 1'b1;
            if (st_d.ovf != OVF_MAX) st_d.ovf = st_d.ovf + OVF_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf  = st_q.ovf;
    assign flag = st_q.flag;

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.flag);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (st_q.ovf == '0) && !st_q.flag);
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf == OVF_MAX && !ack) |=> st_q.ovf == OVF_MAX);
    a_r13_wrap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> st_q.ovf == OVF_ONE && st_q.flag);
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer #(
    parameter  int ADDR_W   = 8,
    parameter  int CNT_W    = 20,
    parameter  int OVF_W    = 12,
    parameter  int PRE_LOG2 = 4,
    parameter  int EN_BIT   = 24,
    parameter  int IE_BIT   = 25,
    localparam int DATA_W   = CNT_W + OVF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import ivt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] interval;
        logic             en;
        logic             ie;
    } ctrl_t;

    ctrl_t            ctrl_d, ctrl_q;
    logic             hit;
    reg_sel_e         sel;
    logic             ack;
    logic             tick, run, wrap, flag;
    logic [CNT_W-1:0] cnt;
    logic [OVF_W-1:0] ovf;
    logic [DATA_W-1:0] word;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // decode: aligned words 0x0..0xC only
    always_comb begin
        hit = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0);
        sel = reg_sel_e'(bus_addr[3:2]);
        ack = bus_rd && hit && (sel == SEL_VALUE);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_wr && hit && sel == SEL_CTRL) begin
            ctrl_d.interval = bus_wdata[CNT_W-1:0];
            ctrl_d.en       = bus_wdata[EN_BIT];
            ctrl_d.ie       = bus_wdata[IE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    ivt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .interval(ctrl_q.interval),
        .tick(tick), .cnt(cnt), .run(run), .wrap(wrap)
    );

    ivt_events #(.OVF_W(OVF_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack), .ovf(ovf), .flag(flag)
    );

    always_comb begin
        word = '0;
        unique case (sel)
            SEL_CTRL: begin
                word[CNT_W-1:0] = ctrl_q.interval;
                word[EN_BIT]    = ctrl_q.en;
                word[IE_BIT]    = ctrl_q.ie;
            end
            SEL_STAT:  word[0] = flag;
            SEL_VALUE, SEL_IMAGE: word = {ovf, cnt};
        endcase
        bus_rdata = (bus_rd && hit) ? word : '0;
    end

    assign irq = flag && ctrl_q.ie;

    // R12: control holds unless written at its own aligned offset
    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit && sel == SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int e0;
    bit done   = 0;

    localparam logic [31:0] EN = 32'h0100_0000;
    localparam logic [31:0] IE = 32'h0200_0000;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    // call at a negedge; uses no clock edge
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        #1 bus_rd = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        e0 = cyc;
    endtask

    // call at a negedge; the acknowledge lands on the next edge
    task automatic read_value(output logic [31:0] d);
        bus_addr = 8'h08; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic stop_and_idle();
        logic [31:0] d;
        write_reg(8'h00, 32'h0000_0000);
        peek(8'h0C, d);
        while (d[19:0] != 0) begin
            @(negedge clk);
            peek(8'h0C, d);
        end
        @(negedge clk);
        read_value(d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        peek(8'h00, d); check("R11 ctrl after reset", d, 0);
        peek(8'h04, d); check("R11 status after reset", d, 0);
        peek(8'h0C, d); check("R11 image after reset", d, 0);
        check("R11 irq after reset", {31'b0, irq}, 0);
        check("R1 rdata idle without strobe", bus_rdata, 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        write_reg(8'h00, IE | EN | 32'd3);
        peek(8'h00, d); check("R2 ctrl readback", d, 32'h0300_0003);
        wait_until(e0 + 15); peek(8'h0C, d); check("R3 before first tick", d, 0);
        wait_until(e0 + 16); peek(8'h0C, d); check("R3 first tick", d, 32'h0000_0001);
        wait_until(e0 + 63); peek(8'h0C, d); check("R4 at interval", d, 32'h0000_0003);
        check("R8 irq low before wrap", {31'b0, irq}, 0);
        wait_until(e0 + 64); peek(8'h0C, d); check("R5 after wrap", d, 32'h0010_0000);
        peek(8'h04, d); check("R5 status set", d, 1);
        check("R8 irq high", {31'b0, irq}, 1);
        peek(8'h0C, d); peek(8'h0C, d);
        peek(8'h04, d); check("R6 image keeps status", d, 1);
        read_value(d); check("R6 value read word", d, 32'h0010_0000);
        peek(8'h04, d); check("R6 status cleared", d, 0);
        peek(8'h0C, d); check("R6 count cleared", d & 32'hFFF0_0000, 0);
        check("R8 irq dropped", {31'b0, irq}, 0);
        wait_until(e0 + 255); peek(8'h0C, d); check("R5 two more", d, 32'h0020_0003);
        wait_until(e0 + 256); peek(8'h0C, d); check("R5 three more", d, 32'h0030_0000);
    endtask

    task automatic t_irq_mask();
        logic [31:0] d;
        write_reg(8'h00, EN | 32'd3);
        check("R8 masked irq", {31'b0, irq}, 0);
        peek(8'h04, d); check("R8 flag kept while masked", d, 1);
        write_reg(8'h00, IE | EN | 32'd3);
        check("R8 unmasked irq", {31'b0, irq}, 1);
        stop_and_idle();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        write_reg(8'h00, 32'd5);
        write_reg(8'h04, 32'hFFFF_FFFF);
        write_reg(8'h08, 32'hFFFF_FFFF);
        write_reg(8'h0C, 32'hFFFF_FFFF);
        write_reg(8'h10, 32'hFFFF_FFFF);
        write_reg(8'h01, 32'hFFFF_FFFF);
        peek(8'h00, d); check("R12 ctrl unchanged", d, 32'd5);
        peek(8'h04, d); check("R12 status unchanged", d, 0);
        peek(8'h0C, d); check("R12 image unchanged", d, 0);
        peek(8'h10, d); check("R12 unmapped read", d, 0);
        peek(8'h40, d); check("R12 high unmapped read", d, 0);
        write_reg(8'h00, 32'hFFFF_FFFF);
        peek(8'h00, d); check("R1 ctrl reserved bits", d, 32'h030F_FFFF);
        write_reg(8'h00, 32'h0);
        peek(8'h0C, d); check("R7 quick disable stays 0", d, 0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        write_reg(8'h00, IE | EN | 32'd5);
        wait_until(e0 + 53); peek(8'h0C, d); check("R7 mid count", d, 32'd3);
        begin
            int s = e0;
            write_reg(8'h00, IE | 32'd5);
            e0 = s;
        end
        wait_until(e0 + 70); peek(8'h0C, d); check("R7 keeps counting", d, 32'd4);
        wait_until(e0 + 95); peek(8'h0C, d); check("R7 reaches interval", d, 32'd5);
        wait_until(e0 + 96); peek(8'h0C, d); check("R7 final wrap counted", d, 32'h0010_0000);
        check("R7 irq on final wrap", {31'b0, irq}, 1);
        wait_until(e0 + 150); peek(8'h0C, d); check("R7 holds at zero", d, 32'h0010_0000);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        write_reg(8'h00, IE | EN | 32'd1);
        wait_until(e0 + 31);
        read_value(d); check("R13 read returns pre-wrap word", d, 32'h0010_0001);
        peek(8'h0C, d); check("R13 wrap kept after ack", d, 32'h0010_0000);
        peek(8'h04, d); check("R13 flag kept after ack", d, 1);
        stop_and_idle();
    endtask

    task automatic t_new_interval();
        logic [31:0] d;
        int s;
        write_reg(8'h00, EN | 32'd7);
        s = e0;
        wait_until(s + 40);
        write_reg(8'h00, EN | 32'd2);
        wait_until(s + 127); peek(8'h0C, d); check("R10 old interval kept", d, 32'd7);
        wait_until(s + 128); peek(8'h0C, d); check("R10 wrap at old interval", d[19:0], 0);
        wait_until(s + 175); peek(8'h0C, d); check("R10 new interval", d[19:0], 32'd2);
        wait_until(s + 176); peek(8'h0C, d); check("R10 wrap at new interval", d[19:0], 0);
        stop_and_idle();
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        write_reg(8'h00, EN | 32'd0);
        wait_until(e0 + 16 * 4094); peek(8'h0C, d); check("R9 below max", d, 32'hFFE0_0000);
        wait_until(e0 + 16 * 4100); peek(8'h0C, d); check("R9 saturated", d, 32'hFFF0_0000);
        wait_until(e0 + 16 * 4100 + 40); peek(8'h0C, d); check("R9 stays saturated", d, 32'hFFF0_0000);
        stop_and_idle();
    endtask

    task automatic t_reset_midrun();
        logic [31:0] d;
        write_reg(8'h00, IE | EN | 32'd2);
        wait_until(e0 + 40);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(8'h00, d); check("R11 ctrl after mid reset", d, 0);
        peek(8'h0C, d); check("R11 image after mid reset", d, 0);
        repeat (40) @(negedge clk);
        peek(8'h0C, d); check("R11 counter stopped", d, 0);
        check("R11 irq low", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_irq_mask();
        t_unmapped();
        t_disable();
        t_collide();
        t_new_interval();
        t_saturate();
        t_reset_midrun();
        done = 1;
        finish_run();
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end
endmodule